// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for every beat of a fixed-length memory burst. A load cycle captures an external start address and begins a burst. Each later continue cycle moves on to the next beat. Only the low offset bits change while the burst runs; the upper bits keep the value that was loaded. The order of the beats is picked when the burst is loaded: an interleaved order that XORs the beat number into the start offset, or a linear order that adds the beat number to the start offset modulo the group size.

A memory controller places the block beside its address register. The controller pulses the active-low load strobe together with a fresh address, then holds the strobe high to step through the beats. Deasserting the clock enable freezes everything, which gives a stall cycle in the middle of a burst. With the default parameters the address is 17 bits and a burst has four beats.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `burst_active` is 0 and `beat_addr` is 0.
- R2: On a clock edge with `clk_en`=1 and `load_n`=0, `start_addr` is captured. From that edge on, `beat_addr` equals `start_addr` and `burst_active` is 1.
- R3: In a burst loaded with `order_sel`=1 (interleaved), the low two bits of `beat_addr` on beat k (k=0..3, with k=0 the load beat) equal `start_addr[1:0]` XOR k.
- R4: In a burst loaded with `order_sel`=0 (linear), the low two bits of `beat_addr` on beat k equal (`start_addr[1:0]` + k) mod 4.
- R5: During a burst, bits [16:2] of `beat_addr` always equal bits [16:2] of the loaded start address, so a burst never leaves its four-word group.
- R6: A continue edge (`clk_en`=1, `load_n`=1) after beat 3 returns to beat 0, the start offset, and `burst_active` stays 1.
- R7: On an edge with `clk_en`=0, `beat_addr` and `burst_active` keep their values whatever `load_n`, `start_addr` and `order_sel` are, and the burst later resumes from the beat where it stopped.
- R8: Continue edges with no load since reset leave `beat_addr` at 0 and `burst_active` at 0.
- R9: The ordering is fixed at the load edge. Changing `order_sel` during a burst has no effect on the beat addresses of that burst.
- R10: A load edge during a burst abandons it and starts a new burst at beat 0 of the new start address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; 0 freezes all state (stall) |
| load_n | input | 1 | 0 = load a new start address, 1 = continue the burst |
| order_sel | input | 1 | Sampled at load: 1 = interleaved, 0 = linear |
| start_addr | input | 17 | External start address |
| beat_addr | output | 17 | Address of the current beat |
| burst_active | output | 1 | 1 once a burst has been loaded |

## Verification
Every start offset is run under both orderings. An implementation that mixes up XOR and addition, or that counts the beats in the wrong direction, gives a wrong low-bit sequence. With the start offset at 3, a linear order must wrap to offset 0. A carry that leaks into bit 2 shows up there as a changed upper field. The bench holds the clock enable low while it offers a load, a new address and a new mode, and expects a frozen state followed by a resume at the same beat. A design that lets the load bypass the enable fails that check. The bench also toggles the order pin in the middle of a burst, which catches ordering that is decoded live instead of latched at load. Continue requests sent straight after reset catch a design that starts counting from an unloaded state.

// File: rtl/bas_pkg.sv
package bas_pkg;
   localparam int unsigned BAS_ADDR_W = 17;
   localparam int unsigned BAS_OFS_W  = 2;

   typedef enum logic {
      ORD_LINEAR      = 1'b0,
      ORD_INTERLEAVED = 1'b1
   } bas_order_e;
endpackage

// File: rtl/bas_beat_counter.sv
module bas_beat_counter #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   if (CNT_W < 1) begin : g_bad_w
      $error("bas_beat_counter: CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (adv) count <= count + CNT_ONE;
   end

   // R6: the beat after the last one is beat 0
   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && count == {CNT_W{1'b1}}) |=> count == '0);
   // R10: a load restarts the beat count
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == '0);
endmodule

// File: rtl/bas_burst_ctx.sv
module bas_burst_ctx #(
   parameter int unsigned ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] d_addr,
   input  logic              d_mode,
   output logic [ADDR_W-1:0] base,
   output logic              mode,
   output logic              active
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base   <= '0;
         mode   <= 1'b0;
         active <= 1'b0;
      end else if (ld) begin
         base   <= d_addr;
         mode   <= d_mode;
         active <= 1'b1;
      end
   end

   // R9: the latched ordering changes only when a load happens
   a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(mode));
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map #(
   parameter int unsigned OFS_W = 2
) (
   input  logic [OFS_W-1:0] ofs,
   input  logic [OFS_W-1:0] beat,
   input  logic             interleave,
   output logic [OFS_W-1:0] ofs_out
);
   logic [OFS_W-1:0] il_ofs;
   logic [OFS_W-1:0] lin_ofs;

   if (OFS_W < 1 || OFS_W > 8) begin : g_bad_w
      $error("bas_order_map: OFS_W out of range");
   end

   for (genvar b = 0; b < OFS_W; b++) begin : g_il_bit
      assign il_ofs[b] = ofs[b] ^ beat[b];
   end

   assign lin_ofs = ofs + beat;
   assign ofs_out = interleave ? il_ofs : lin_ofs;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bas_pkg::*;
#(
   parameter int unsigned ADDR_W = BAS_ADDR_W,
   parameter int unsigned OFS_W  = BAS_OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              load_n,
   input  logic              order_sel,
   input  logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] beat_addr,
   output logic              burst_active
);
   localparam int unsigned UP_W = ADDR_W - OFS_W;

   if (ADDR_W <= OFS_W) begin : g_bad_split
      $error("burst_addr_seq: ADDR_W must exceed OFS_W");
   end

   logic              do_load;
   logic              do_step;
   logic [ADDR_W-1:0] base;
   logic              mode_q;
   logic [OFS_W-1:0]  beat;
   logic [OFS_W-1:0]  low_ofs;

   assign do_load = clk_en && !load_n;
   assign do_step = clk_en && load_n && burst_active;

   bas_burst_ctx #(.ADDR_W(ADDR_W)) u_ctx (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (do_load),
      .d_addr (start_addr),
      .d_mode (order_sel),
      .base   (base),
      .mode   (mode_q),
      .active (burst_active)
   );

   bas_beat_counter #(.CNT_W(OFS_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (do_load),
      .adv   (do_step),
      .count (beat)
   );

   bas_order_map #(.OFS_W(OFS_W)) u_map (
      .ofs        (base[OFS_W-1:0]),
      .beat       (beat),
      .interleave (mode_q == ORD_INTERLEAVED),
      .ofs_out    (low_ofs)
   );

   assign beat_addr = {base[ADDR_W-1:OFS_W], low_ofs};

   // R2: a load presents the start address on the next cycle
   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !load_n) |=> (burst_active && beat_addr == $past(start_addr)));
   // R5: the upper field never moves on a continue
   a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && load_n) |=> $stable(beat_addr[ADDR_W-1:OFS_W]));
   // R7: a stall freezes the outputs
   a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(beat_addr) && $stable(burst_active)));
   // R8: no burst loaded means address zero
   a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !burst_active |-> beat_addr == '0);
   // R6: once active, a burst stays active
   a_r6_stays_active: assert property (@(posedge clk) disable iff (!rst_n)
      burst_active |=> burst_active);
   // R3/R4: a continue always changes the low offset
   a_r3_r4_low_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && load_n && burst_active) |=>
         beat_addr[OFS_W-1:0] != $past(beat_addr[OFS_W-1:0]));
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
   localparam int AW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en = 1'b0;
   logic          load_n = 1'b1;
   logic          order_sel = 1'b1;
   logic [AW-1:0] start_addr = '0;
   logic [AW-1:0] beat_addr;
   logic          burst_active;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   burst_addr_seq u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .clk_en       (clk_en),
      .load_n       (load_n),
      .order_sel    (order_sel),
      .start_addr   (start_addr),
      .beat_addr    (beat_addr),
      .burst_active (burst_active)
   );

   function automatic logic [AW-1:0] model(input logic [AW-1:0] s, input int k, input logic il);
      logic [1:0] kk;
      logic [1:0] lo;
      kk = k[1:0];
      lo = il ? (s[1:0] ^ kk) : (s[1:0] + kk);
      return {s[AW-1:2], lo};
   endfunction

   task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // one edge, then sample 5 ns later (inputs also change there)
   task automatic step();
      @(posedge clk);
      #5;
   endtask

   task automatic do_load(input logic [AW-1:0] a, input logic il);
      clk_en = 1'b1; load_n = 1'b0; start_addr = a; order_sel = il;
      step();
      load_n = 1'b1; start_addr = '0;
   endtask

   task automatic t_reset();
      chk("R1 addr", beat_addr, '0);
      chk("R1 active", {16'b0, burst_active}, 17'd0);
   endtask

   task automatic t_idle_continue();
      clk_en = 1'b1; load_n = 1'b1; start_addr = 17'h1FFFF;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R8 addr", beat_addr, '0);
         chk("R8 active", {16'b0, burst_active}, 17'd0);
      end
   endtask

   task automatic t_sequence(input logic [AW-1:0] a, input logic il, input string req);
      do_load(a, il);
      chk("R2 load", beat_addr, a);
      chk("R2 active", {16'b0, burst_active}, 17'd1);
      for (int k = 1; k <= 4; k++) begin
         step();
         chk(req, beat_addr, model(a, k, il));
         chk("R5 upper", {2'b0, beat_addr[AW-1:2]}, {2'b0, a[AW-1:2]});
      end
      chk("R6 wrapped", beat_addr, a);
      chk("R6 active", {16'b0, burst_active}, 17'd1);
   endtask

   task automatic t_stall();
      logic [AW-1:0] a;
      a = 17'h0A5F1;
      do_load(a, 1'b0);
      step();
      chk("R4 beat1", beat_addr, model(a, 1, 1'b0));
      clk_en = 1'b0; load_n = 1'b0; start_addr = 17'h12345; order_sel = 1'b1;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R7 held", beat_addr, model(a, 1, 1'b0));
      end
      clk_en = 1'b1; load_n = 1'b1; start_addr = '0;
      step();
      chk("R7 resume", beat_addr, model(a, 2, 1'b0));
   endtask

   task automatic t_mode_change();
      logic [AW-1:0] a;
      a = 17'h1C001;
      do_load(a, 1'b1);
      order_sel = 1'b0;
      for (int k = 1; k <= 3; k++) begin
         step();
         chk("R9 mode latched", beat_addr, model(a, k, 1'b1));
      end
   endtask

   task automatic t_reload();
      logic [AW-1:0] a;
      logic [AW-1:0] b;
      a = 17'h03332; b = 17'h1EEE7;
      do_load(a, 1'b1);
      step();
      step();
      do_load(b, 1'b0);
      chk("R10 restart", beat_addr, b);
      step();
      chk("R10 next", beat_addr, model(b, 1, 1'b0));
   endtask

   initial begin
      #100000;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #35;
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_idle_continue();
      t_sequence(17'h1ABC6, 1'b1, "R3 interleaved");
      t_sequence(17'h0F003, 1'b0, "R4 linear");
      for (int o = 0; o < 4; o++) begin
         t_sequence({15'h2D4B, o[1:0]}, 1'b1, "R3 all offsets");
         t_sequence({15'h52B4, o[1:0]}, 1'b0, "R4 all offsets");
      end
      t_stall();
      t_mode_change();
      t_reload();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule